// File: doc/BRIEF.md
# Multimodulus Selectable Clock Prescaler

This block divides a fast clock by one of four ratios and marks the end of each division period with a single-cycle pulse. A small dual-modulus core counter runs once per core cycle. It counts either N1 or N1+1 input clocks per cycle, with N1 = 2 or 4 chosen by a parameter. A chain of four binary divide-by-two stages counts sixteen core cycles, and each pass of that chain is one output period. Everything runs synchronously on the input clock; the divider stages are counter enables, not derived clocks.

The core normally runs at one modulus and switches to the other for exactly one core cycle per output period. That cycle is the last one, when every chain stage sits at one. Two inputs set the ratio. The band input flips the sense of the core's modulus control, so the base modulus becomes N1+1 instead of N1. The swallow input enables the single-cycle modulus change. With N1 = 2 the ratios are 32, 33, 48 and 47; with N1 = 4 they are 64, 65, 80 and 79. Both inputs are captured only at a period boundary, so every period has one clean ratio.

Top module: `mm_prescaler`

## Requirements
- R1: While `rst` is high at a rising edge, the core and the chain clear and `pulse_o` stays low. The first `pulse_o` comes in the P-th cycle after reset is released, where P is the ratio set by the inputs held during reset.
- R2: With `band_i` = 0 and `swallow_i` = 0, pulses are 16·N1 input clocks apart (32 for N1 = 2).
- R3: With `band_i` = 0 and `swallow_i` = 1, pulses are 16·N1 + 1 input clocks apart (33 for N1 = 2).
- R4: With `band_i` = 1 and `swallow_i` = 0, pulses are 16·(N1+1) input clocks apart (48 for N1 = 2).
- R5: With `band_i` = 1 and `swallow_i` = 1, pulses are 16·(N1+1) − 1 input clocks apart (47 for N1 = 2).
- R6: `pulse_o` is high for exactly one input clock per period.
- R7: `swallow_i` and `band_i` are sampled only at the rising edge where `pulse_o` is high, or under reset. A change at any other time does not alter the period in progress; it takes effect from the next period on.
- R8: With the parameter `CORE_N1` = 4, the four ratios are 64, 65, 80 and 79, under the same input encoding as R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| swallow_i | input | 1 | 1: change the core modulus for one core cycle per period |
| band_i | input | 1 | 1: inverts the core modulus control (base modulus N1+1) |
| pulse_o | output | 1 | One-clock pulse in the last cycle of each period |

## Verification
The hardest case to reach is a change of `swallow_i` or `band_i` in the middle of a period, especially close to the boundary cycle. There a design that samples the inputs live would produce a period of mixed ratio. The stimulus changes the inputs at random cycle offsets, often several times within one period. The bench model fixes each period's expected length from the inputs present at the cycle that opened it. Directed runs hold each of the four input combinations for several periods. A reset is also applied in the middle of a period. Two instances with N1 = 2 and N1 = 4 see the same stimulus.

// File: rtl/mm_prescaler_pkg.sv
package mm_prescaler_pkg;

   typedef struct packed {
      logic swallow;
      logic band;
   } mm_cfg_t;

endpackage

// File: rtl/mm_core_div.sv
module mm_core_div #(
   parameter int N1 = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic short_i,
   output logic tc_o
);
   localparam int CW = $clog2(N1 + 2);
   localparam logic [CW-1:0] LAST_SHORT = CW'(N1 - 1);
   localparam logic [CW-1:0] LAST_LONG  = CW'(N1);

   logic [CW-1:0] cnt_q;

   generate
      if (N1 < 2) begin : g_bad_n1
         $error("mm_core_div: N1 must be at least 2");
      end
   endgenerate

   assign tc_o = (cnt_q == (short_i ? LAST_SHORT : LAST_LONG));

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (tc_o) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   a_r2_core_range: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST_LONG);

   a_r3_core_wrap: assert property (@(posedge clk) disable iff (rst)
      tc_o |=> (cnt_q == '0));

endmodule

// File: rtl/mm_div2_chain.sv
module mm_div2_chain #(
   parameter int STAGES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic step_i,
   output logic full_o
);
   logic [STAGES-1:0] q;
   logic [STAGES:0]   carry;

   generate
      if (STAGES < 1 || STAGES > 8) begin : g_bad_stages
         $error("mm_div2_chain: STAGES must be in 1..8");
      end
   endgenerate

   assign carry[0] = step_i;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      assign carry[k+1] = carry[k] & q[k];
      always_ff @(posedge clk) begin
         if (rst)           q[k] <= 1'b0;
         else if (carry[k]) q[k] <= ~q[k];
      end
   end

   assign full_o = &q;

   a_r2_chain_step: assert property (@(posedge clk) disable iff (rst)
      step_i |=> (q == STAGES'($past(q) + 1'b1)));

   a_r2_chain_hold: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(q));

endmodule

// File: rtl/mm_mode_ctrl.sv
module mm_mode_ctrl
   import mm_prescaler_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic swallow_i,
   input  logic band_i,
   input  logic load_i,
   input  logic last_i,
   output logic short_o
);
   mm_cfg_t cfg_q;
   logic    swap;

   always_ff @(posedge clk) begin
      if (rst || load_i) begin
         cfg_q.swallow <= swallow_i;
         cfg_q.band    <= band_i;
      end
   end

   assign swap    = cfg_q.swallow & last_i;
   assign short_o = cfg_q.band ^ ~swap;

   a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/mm_prescaler.sv
module mm_prescaler #(
   parameter int CORE_N1 = 2,
   parameter int STAGES  = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic swallow_i,
   input  logic band_i,
   output logic pulse_o
);
   logic short_mod;
   logic core_tc;
   logic chain_full;
   logic period_end;

   generate
      if (CORE_N1 != 2 && CORE_N1 != 4) begin : g_bad_core
         $error("mm_prescaler: CORE_N1 must be 2 or 4");
      end
   endgenerate

   mm_mode_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .swallow_i (swallow_i),
      .band_i    (band_i),
      .load_i    (period_end),
      .last_i    (chain_full),
      .short_o   (short_mod)
   );

   mm_core_div #(.N1(CORE_N1)) u_core (
      .clk     (clk),
      .rst     (rst),
      .short_i (short_mod),
      .tc_o    (core_tc)
   );

   mm_div2_chain #(.STAGES(STAGES)) u_chain (
      .clk    (clk),
      .rst    (rst),
      .step_i (core_tc),
      .full_o (chain_full)
   );

   assign period_end = core_tc & chain_full;
   assign pulse_o    = period_end;

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      pulse_o |=> !pulse_o);

   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> !pulse_o);

endmodule

// File: tb/mm_prescaler_tb.sv
`timescale 1ns/1ps
module mm_prescaler_tb;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic swallow = 1'b0;
   logic band = 1'b0;
   logic pulse_a, pulse_b;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mm_prescaler #(.CORE_N1(2)) u_dut (
      .clk(clk), .rst(rst), .swallow_i(swallow), .band_i(band), .pulse_o(pulse_a));

   mm_prescaler #(.CORE_N1(4)) u_dut_b (
      .clk(clk), .rst(rst), .swallow_i(swallow), .band_i(band), .pulse_o(pulse_b));

   function automatic int ratio(int n1, bit sw, bit bd);
      int base;
      base = bd ? n1 + 1 : n1;
      if (!sw)     return 16 * base;
      else if (bd) return 16 * base - 1;
      else         return 16 * base + 1;
   endfunction

   function automatic string tag(bit sw, bit bd);
      if (!bd) return sw ? "R3" : "R2";
      return sw ? "R5" : "R4";
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // per-instance monitor state
   int  cyc_a = 0, exp_a = 0, cyc_b = 0, exp_b = 0;
   bit  sw_a, bd_a, chg_a, sw_b, bd_b, chg_b;
   bit  prev_a = 0, prev_b = 0;
   int  pulses_a = 0;

   always @(negedge clk) begin
      if (!done) begin
         if (rst) begin
            check(pulse_a == 1'b0, "R1", int'(pulse_a), 0);
            check(pulse_b == 1'b0, "R1/R8", int'(pulse_b), 0);
            sw_a = swallow; bd_a = band; exp_a = ratio(2, swallow, band); cyc_a = 0; chg_a = 0;
            sw_b = swallow; bd_b = band; exp_b = ratio(4, swallow, band); cyc_b = 0; chg_b = 0;
            prev_a = 0; prev_b = 0;
         end else begin
            cyc_a++;
            cyc_b++;
            if (swallow != sw_a || band != bd_a) chg_a = 1;
            if (swallow != sw_b || band != bd_b) chg_b = 1;
            if (prev_a && pulse_a) check(0, "R6", 1, 0);
            if (prev_b && pulse_b) check(0, "R6/R8", 1, 0);
            if (pulse_a) begin
               check(cyc_a == exp_a, chg_a ? "R7" : tag(sw_a, bd_a), cyc_a, exp_a);
               pulses_a++;
               sw_a = swallow; bd_a = band; exp_a = ratio(2, swallow, band); cyc_a = 0; chg_a = 0;
            end else if (cyc_a > exp_a) begin
               check(0, tag(sw_a, bd_a), cyc_a, exp_a);
               cyc_a = 0;
            end
            if (pulse_b) begin
               check(cyc_b == exp_b, chg_b ? "R8/R7" : "R8", cyc_b, exp_b);
               sw_b = swallow; bd_b = band; exp_b = ratio(4, swallow, band); cyc_b = 0; chg_b = 0;
            end else if (cyc_b > exp_b) begin
               check(0, "R8", cyc_b, exp_b);
               cyc_b = 0;
            end
            prev_a = pulse_a;
            prev_b = pulse_b;
         end
      end
   end

   task automatic drive(bit sw, bit bd);
      @(posedge clk);
      #1;
      swallow = sw;
      band = bd;
   endtask

   task automatic wait_pulses(int n);
      int target;
      target = pulses_a + n;
      while (pulses_a < target) @(posedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      // directed: each combination held for several periods (R2..R5, R8)
      for (int c = 0; c < 4; c++) begin
         wait_pulses(1);
         drive(c[0], c[1]);
         wait_pulses(5);
      end
      // mid-period reset with band=1, swallow=1 held in reset (R1)
      repeat (17) @(posedge clk);
      #1 rst = 1'b1; swallow = 1'b1; band = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      wait_pulses(3);
      // constrained random changes at arbitrary offsets (R7)
      for (int i = 0; i < 400; i++) begin
         int gap;
         gap = 1 + int'($urandom_range(0, 90));
         repeat (gap) @(posedge clk);
         #1;
         swallow = 1'($urandom_range(0, 1));
         band = 1'($urandom_range(0, 1));
      end
      wait_pulses(3);
      @(negedge clk);
      finish_run();
   end

endmodule